// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block sits between a bank of internally generated lane clocks and their output drivers. Each lane's raw clock (`phaseIn`) is re-timed on the fast system clock. The lane is then either passed through or parked at a fixed level, depending on four things:

- two global stop requests, one for the processor group and one for the peripheral/serial group;
- a set of clock-request inputs, each routed to lanes through a map;
- a per-lane stoppable bit;
- a per-lane output-enable bit.

Lanes are either differential, with true and complement legs, or single-ended, with a true leg only. The complement output of a single-ended lane stays low.

The parked level depends on why a lane stopped. A global stop holds a differential lane with true high and complement low. A clock-request stop or an output-enable disable holds both legs low. Single-ended lanes always park low.

Mode changes take effect only at an edge of the lane's own clock. As a result, every high or low pulse on an output lasts at least one half period of that lane's clock. One lane is switchable: a strap input places it in the processor group or in the serial group.

Top module: `clkStopGate`

## Requirements
- R1: While `rstN` is low, every `outTrue` and `outComp` bit is 0.
- R2: A differential lane with its stoppable bit set and its output enable set parks with true=1 and complement=0 while its group's stop input is low (`cpuStopN` for processor lanes, `pciStopN` for the others). This applies only when no clock-request stop hits the lane.
- R3: A single-ended lane with its stoppable bit set and its output enable set drives true=0 while `pciStopN` is low.
- R4: Bit `reqMap[lane*NUM_REQ+k]`=1 routes `clkReqN[k]` to that lane. A value of 1 on `clkReqN[k]` means "not requested". A stoppable, enabled, non-processor lane with any routed request at 1 drives both legs 0. This takes priority over a global stop. Processor-group lanes ignore clock requests.
- R5: A lane whose `laneOe` bit is 0 drives both legs 0, whatever its other settings.
- R6: A lane whose `stopAllow` bit is 0 and whose enable is 1 keeps running through global stops and clock-request stops.
- R7: Lane `SWITCH_LANE` follows the processor-group rules when `strapCpu`=1, and the serial-group rules when `strapCpu`=0.
- R8: A running lane drives `outTrue` equal to `phaseIn` one `clk` cycle later. A running differential lane drives `outComp` as its inverse. True and complement are never both 1.
- R9: Between two changes of `outTrue`, at least one half period of that lane's `phaseIn` elapses. Entering or leaving a park never shortens a pulse.
- R10: `outTrue` changes only in the cycle after an edge of that lane's `phaseIn`.
- R11: `outComp` of a single-ended lane is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples and re-times all lanes |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseIn | input | NUM_LANES | Raw lane clocks, synchronous to `clk` |
| cpuStopN | input | 1 | Active-low stop for processor-group lanes (asynchronous) |
| pciStopN | input | 1 | Active-low stop for peripheral/serial lanes (asynchronous) |
| clkReqN | input | NUM_REQ | Clock requests, 0 = requested (asynchronous) |
| laneOe | input | NUM_LANES | Per-lane output enable |
| stopAllow | input | NUM_LANES | Per-lane stoppable bit (0 = free running) |
| reqMap | input | NUM_LANES*NUM_REQ | Routing of clock requests to lanes |
| strapCpu | input | 1 | Places the switchable lane in the processor group |
| outTrue | output | NUM_LANES | Gated true legs |
| outComp | output | NUM_LANES | Gated complement legs (0 on single-ended lanes) |

## Verification
The assertions assume the following about the inputs:

- `phaseIn` changes only between `clk` edges.
- The configuration inputs (`laneOe`, `stopAllow`, `reqMap`, `strapCpu`) come from the `clk` domain.

Only the stop and request pins are treated as asynchronous. The stimulus respects this:

- The bench toggles each lane clock on the falling edge of `clk`, with half periods of two to five cycles.
- It changes every control and configuration input just after a rising edge.
- It holds each configuration long enough for the synchronizer, the registered command and one lane edge to settle before it inspects the outputs.

// File: rtl/gatePkg.sv
package gatePkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_PARK_HI = 2'd1,
    MODE_PARK_LO = 2'd2
  } laneMode_e;

  // strobes from control to datapath, one per lane
  typedef struct packed {
    logic holdHi;
    logic holdLo;
  } laneCmd_t;

endpackage

// File: rtl/stopSync.sv
module stopSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gateControl.sv
module gateControl
  import gatePkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int NUM_REQ = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LANES-1:0] DIFF_MASK = 8'b0011_1111,
  parameter logic [NUM_LANES-1:0] CPU_MASK = 8'b0000_0011,
  parameter int SWITCH_LANE = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuStopN,
  input  logic                         pciStopN,
  input  logic [NUM_REQ-1:0]           clkReqN,
  input  logic [NUM_LANES-1:0]         laneOe,
  input  logic [NUM_LANES-1:0]         stopAllow,
  input  logic [NUM_LANES*NUM_REQ-1:0] reqMap,
  input  logic                         strapCpu,
  output laneCmd_t [NUM_LANES-1:0]     cmd
);

  localparam int SYNC_W = NUM_REQ + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {NUM_REQ{1'b0}}};

  logic [SYNC_W-1:0] syncBus;
  logic              cpuStopHit;
  logic              pciStopHit;
  logic [NUM_REQ-1:0] reqIdle;

  stopSync #(
    .WIDTH(SYNC_W),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({cpuStopN, pciStopN, clkReqN}),
    .syncOut(syncBus)
  );

  assign cpuStopHit = ~syncBus[NUM_REQ+1];
  assign pciStopHit = ~syncBus[NUM_REQ];
  assign reqIdle    = syncBus[NUM_REQ-1:0];

  laneCmd_t [NUM_LANES-1:0] cmdNext;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam bit IS_DIFF = DIFF_MASK[g];
    localparam bit IS_SWITCH = (g == SWITCH_LANE);

    logic inCpuGroup;
    logic reqStop;
    logic groupStop;

    if (IS_SWITCH) begin : g_sw
      assign inCpuGroup = CPU_MASK[g] | strapCpu;
    end else begin : g_fix
      assign inCpuGroup = CPU_MASK[g];
    end

    assign reqStop   = ~inCpuGroup & (|(reqMap[g*NUM_REQ +: NUM_REQ] & reqIdle));
    assign groupStop = inCpuGroup ? cpuStopHit : pciStopHit;

    // priority: enable disable, then clock request, then global stop
    always_comb begin
      cmdNext[g] = '0;
      if (!laneOe[g]) begin
        cmdNext[g].holdLo = 1'b1;
      end else if (stopAllow[g] && reqStop) begin
        cmdNext[g].holdLo = 1'b1;
      end else if (stopAllow[g] && groupStop) begin
        if (IS_DIFF) cmdNext[g].holdHi = 1'b1;
        else         cmdNext[g].holdLo = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        cmd[i].holdHi <= 1'b0;
        cmd[i].holdLo <= 1'b1;
      end
    end else begin
      cmd <= cmdNext;
    end
  end

endmodule

// File: rtl/gateLane.sv
module gateLane
  import gatePkg::*;
#(
  parameter bit IS_DIFF = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     phaseIn,
  input  laneCmd_t cmd,
  output logic     outTrue,
  output logic     outComp
);

  laneMode_e mode;
  laneMode_e cmdMode;
  laneMode_e modeNext;
  logic      phaseD;
  logic      phaseEdge;

  always_comb begin
    if (cmd.holdLo)      cmdMode = MODE_PARK_LO;
    else if (cmd.holdHi) cmdMode = IS_DIFF ? MODE_PARK_HI : MODE_PARK_LO;
    else                 cmdMode = MODE_RUN;
  end

  assign phaseEdge = phaseIn ^ phaseD;
  assign modeNext  = phaseEdge ? cmdMode : mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_PARK_LO;
      phaseD  <= 1'b0;
      outTrue <= 1'b0;
    end else begin
      mode    <= modeNext;
      phaseD  <= phaseIn;
      outTrue <= (modeNext == MODE_RUN) ? phaseIn : (modeNext == MODE_PARK_HI);
    end
  end

  if (IS_DIFF) begin : g_diff
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outComp <= 1'b0;
      else       outComp <= (modeNext == MODE_RUN) & ~phaseIn;
    end
  end else begin : g_se
    assign outComp = 1'b0;
  end

endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import gatePkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter logic [NUM_LANES-1:0] DIFF_MASK = 8'b0011_1111
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_LANES-1:0]     phaseIn,
  input  laneCmd_t [NUM_LANES-1:0] cmd,
  output logic [NUM_LANES-1:0]     outTrue,
  output logic [NUM_LANES-1:0]     outComp
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    gateLane #(.IS_DIFF(DIFF_MASK[g])) u_lane (
      .clk(clk),
      .rstN(rstN),
      .phaseIn(phaseIn[g]),
      .cmd(cmd[g]),
      .outTrue(outTrue[g]),
      .outComp(outComp[g])
    );
  end

endmodule

// File: rtl/clkStopGate.sv
module clkStopGate
  import gatePkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int NUM_REQ = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LANES-1:0] DIFF_MASK = 8'b0011_1111,
  parameter logic [NUM_LANES-1:0] CPU_MASK = 8'b0000_0011,
  parameter int SWITCH_LANE = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LANES-1:0]         phaseIn,
  input  logic                         cpuStopN,
  input  logic                         pciStopN,
  input  logic [NUM_REQ-1:0]           clkReqN,
  input  logic [NUM_LANES-1:0]         laneOe,
  input  logic [NUM_LANES-1:0]         stopAllow,
  input  logic [NUM_LANES*NUM_REQ-1:0] reqMap,
  input  logic                         strapCpu,
  output logic [NUM_LANES-1:0]         outTrue,
  output logic [NUM_LANES-1:0]         outComp
);

  laneCmd_t [NUM_LANES-1:0] cmd;

  gateControl #(
    .NUM_LANES(NUM_LANES),
    .NUM_REQ(NUM_REQ),
    .SYNC_STAGES(SYNC_STAGES),
    .DIFF_MASK(DIFF_MASK),
    .CPU_MASK(CPU_MASK),
    .SWITCH_LANE(SWITCH_LANE)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cpuStopN(cpuStopN),
    .pciStopN(pciStopN),
    .clkReqN(clkReqN),
    .laneOe(laneOe),
    .stopAllow(stopAllow),
    .reqMap(reqMap),
    .strapCpu(strapCpu),
    .cmd(cmd)
  );

  gateDatapath #(
    .NUM_LANES(NUM_LANES),
    .DIFF_MASK(DIFF_MASK)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .phaseIn(phaseIn),
    .cmd(cmd),
    .outTrue(outTrue),
    .outComp(outComp)
  );

endmodule

// File: rtl/clkStopGateChecker.sv
module clkStopGateChecker #(
  parameter int NUM_LANES = 8,
  parameter logic [NUM_LANES-1:0] DIFF_MASK = 8'b0011_1111
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LANES-1:0] phaseIn,
  input logic [NUM_LANES-1:0] laneOe,
  input logic [NUM_LANES-1:0] outTrue,
  input logic [NUM_LANES-1:0] outComp
);

  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    // R10
    out_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3 && outTrue[g] != $past(outTrue[g]))
        |-> ($past(phaseIn[g]) != $past(phaseIn[g], 2)));

    // R8
    legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(outTrue[g] && outComp[g]));

    // R5
    oe_keeps_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3 && $past(!laneOe[g]) && !outTrue[g] && !outComp[g])
        |=> (!outTrue[g] && !outComp[g]));

    if (!DIFF_MASK[g]) begin : g_se
      // R11
      se_comp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        outComp[g] == 1'b0);
    end
  end

endmodule

bind clkStopGate clkStopGateChecker #(
  .NUM_LANES(NUM_LANES),
  .DIFF_MASK(DIFF_MASK)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .phaseIn(phaseIn),
  .laneOe(laneOe),
  .outTrue(outTrue),
  .outComp(outComp)
);

// File: tb/tb_clkStopGate.sv
`timescale 1ns/1ps
module tb_clkStopGate;

  localparam int N = 8;
  localparam int NR = 3;
  localparam int WINDOW = 16;
  localparam int SETTLE = 30;

  localparam int M_RUN = 0;
  localparam int M_HI = 1;
  localparam int M_LO = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  phase = '0;
  logic          cpuStopN = 1'b1;
  logic          pciStopN = 1'b1;
  logic [NR-1:0] clkReqN = '0;
  logic [N-1:0]  laneOe = '1;
  logic [N-1:0]  stopAllow = '1;
  logic [N*NR-1:0] reqMap;
  logic          strapCpu = 1'b0;
  logic [N-1:0]  outTrue;
  logic [N-1:0]  outComp;

  int compared = 0;
  int mismatched = 0;

  // routing: lane0 has a bit set on purpose (processor lanes must ignore it)
  assign reqMap = {3'b000, 3'b000, 3'b100, 3'b110, 3'b001, 3'b011, 3'b000, 3'b001};

  always #2 clk = ~clk;

  clkStopGate dut (
    .clk(clk), .rstN(rstN), .phaseIn(phase), .cpuStopN(cpuStopN),
    .pciStopN(pciStopN), .clkReqN(clkReqN), .laneOe(laneOe),
    .stopAllow(stopAllow), .reqMap(reqMap), .strapCpu(strapCpu),
    .outTrue(outTrue), .outComp(outComp)
  );

  function automatic int halfOf(int i);
    return 2 + (i % 4);
  endfunction

  function automatic bit isDiff(int i);
    return i < 6;
  endfunction

  function automatic int expMode(int i);
    bit cpuLane;
    bit reqHit;
    cpuLane = (i < 2) || (i == 5 && strapCpu);
    reqHit  = |(reqMap[i*NR +: NR] & clkReqN);
    if (!laneOe[i]) return M_LO;                                   // R5
    if (stopAllow[i] && !cpuLane && reqHit) return M_LO;           // R4
    if (stopAllow[i] && (cpuLane ? !cpuStopN : !pciStopN))         // R2 R3 R7
      return isDiff(i) ? M_HI : M_LO;
    return M_RUN;                                                  // R6
  endfunction

  // window statistics, written by the falling-edge monitor
  bit winOn = 0;
  bit allHi [N];
  bit allLo [N];
  bit runOk [N];
  int toggles [N];
  int runLen [N];
  bit seenChange [N];
  logic lastT [N];
  int halfCnt [N];

  initial begin
    for (int i = 0; i < N; i++) begin
      runLen[i] = 0; seenChange[i] = 0; lastT[i] = 1'b0; halfCnt[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        logic t, c;
        t = outTrue[i];
        c = outComp[i];
        if (winOn) begin
          if (!(t == 1'b1 && c == 1'b0)) allHi[i] = 0;
          if (!(t == 1'b0 && c == 1'b0)) allLo[i] = 0;
          if (t !== phase[i] || c !== (isDiff(i) ? ~phase[i] : 1'b0)) runOk[i] = 0;
          if (t != lastT[i]) toggles[i]++;
        end
        if (rstN) begin
          if (t != lastT[i]) begin
            // R9: pulse width at least one half period
            if (seenChange[i] && runLen[i] < halfOf(i)) begin
              mismatched++;
              $display("FAIL R9 lane %0d: pulse of %0d cycles, expected >= %0d",
                       i, runLen[i], halfOf(i));
            end
            seenChange[i] = 1;
            runLen[i] = 1;
          end else begin
            runLen[i]++;
          end
        end
        lastT[i] = t;
        halfCnt[i]++;
        if (halfCnt[i] == halfOf(i)) begin
          halfCnt[i] = 0;
          phase[i] = ~phase[i];
        end
      end
    end
  end

  task automatic checkWindow(int c);
    for (int i = 0; i < N; i++) begin
      int m;
      bit ok;
      m = expMode(i);
      compared++;
      case (m)
        M_HI:    ok = allHi[i];
        M_LO:    ok = allLo[i];
        default: ok = runOk[i] && toggles[i] > 0;
      endcase
      if (!ok) begin
        mismatched++;
        $display("FAIL R2/R3/R4/R5/R6/R7/R8 combo %0d lane %0d: actual T=%b C=%b toggles=%0d, expected mode %0d",
                 c, i, outTrue[i], outComp[i], toggles[i], m);
      end
    end
  endtask

  task automatic runCombo(int c);
    int sh;
    logic [7:0] pat;
    @(posedge clk); #1;
    cpuStopN = c[0];
    pciStopN = c[1];
    clkReqN  = c[4:2];
    strapCpu = c[5];
    laneOe   = (c % 9 == 8) ? 8'hFF : (8'hFF ^ (8'h01 << (c % 9)));
    sh = c % 8;
    pat = 8'hB7;
    stopAllow = (pat << sh) | (pat >> (8 - sh));
    repeat (SETTLE) @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      allHi[i] = 1; allLo[i] = 1; runOk[i] = 1; toggles[i] = 0;
    end
    winOn = 1;
    repeat (WINDOW) @(posedge clk);
    #1;
    winOn = 0;
    checkWindow(c);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1
    compared++;
    if (outTrue !== '0 || outComp !== '0) begin
      mismatched++;
      $display("FAIL R1 reset: actual T=%b C=%b expected all zero", outTrue, outComp);
    end
    rstN = 1'b1;
    for (int c = 0; c < 256; c++) runCombo(c);
    // R9 and R10 monitored throughout the sweep
    compared++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule